// File: doc/BRIEF.md
# Fetch-Stage Branch Predictor with Static Fallback

This block predicts the next fetch address for one instruction per cycle. The fetch stage presents the current PC together with a predecoded descriptor. The descriptor gives the kind of branch, a flag that is set when the target lies below the PC, and the decoded target of a direct branch. The block returns a taken flag and the predicted next PC in the same cycle. A direct-mapped target buffer holds a valid bit, a PC tag, a 2-bit saturating direction counter and a target for each entry. A circular return stack supplies return addresses. When the buffer has no entry for a conditional branch, a static rule decides: backward branches are predicted taken and forward branches not taken.

The buffer is written only through a retirement port. That port carries the resolved kind, PC, outcome and target of each retired branch. A lookup and a write in the same cycle read the buffer contents from before the write. Far transfers are never predicted and never written into the buffer.

Top module: `bpred_unit`

## Requirements
- R1: After reset the buffer holds no valid entry and the return stack is empty. A conditional branch (kind 1) that has its backward flag clear predicts not-taken with next PC = PC + 4.
- R2: On a buffer miss, a conditional branch (kind 1) that has its backward flag set predicts taken to the descriptor target. With the flag clear it predicts not-taken to PC + 4.
- R3: On a buffer hit, a conditional branch predicts taken when the entry's counter is 2 or 3. In that case the next PC is the stored target. Otherwise the prediction is not-taken with next PC = PC + 4. The buffer index is PC[7:2] and the tag is PC[31:8].
- R4: A retirement that hits the buffer raises the counter by one when the branch was taken and lowers it by one when it was not. The counter saturates at 3 and at 0.
- R5: A retirement of a near branch (kinds 1 to 5) that misses the buffer allocates the entry at its index. The allocation replaces any entry with a different tag. The new counter is 2 if the branch was taken and 1 if not, and the stored target is the resolved target.
- R6: Fetch lookups never change the buffer. Only the retirement port writes it.
- R7: A lookup in the same cycle as a retirement to the same index returns the contents from before the write. The write is visible from the next cycle.
- R8: A call (kind 3) predicts taken to the descriptor target and pushes PC + 4 onto the return stack.
- R9: A return (kind 4) with a non-empty stack predicts taken to the top entry and pops it. Returns are served in last-in first-out order.
- R10: The return stack has 16 entries. A push to a full stack overwrites the oldest entry, so after 17 calls the next 16 returns receive the 16 newest addresses and the stack is then empty.
- R11: A return with an empty stack uses the buffer: on a hit it predicts taken to the stored target, and on a miss it predicts not-taken to PC + 4.
- R12: A far transfer (kind 6) predicts not-taken to PC + 4 and leaves the stack unchanged. A retired far transfer does not allocate a buffer entry.
- R13: A direct jump (kind 2) predicts taken to the descriptor target. An indirect branch (kind 5) predicts taken to the stored target on a hit and not-taken to PC + 4 on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch descriptor valid; gates the stack push and pop |
| fetch_pc | input | PC_W | Fetch PC |
| fetch_kind | input | 3 | Branch kind: 0 none, 1 conditional, 2 jump, 3 call, 4 return, 5 indirect, 6 far |
| fetch_backward | input | 1 | Set when the decoded target lies below the PC |
| fetch_target | input | PC_W | Decoded target of a direct branch |
| pred_taken | output | 1 | Predicted taken |
| pred_next_pc | output | PC_W | Predicted next fetch PC |
| retire_valid | input | 1 | Retirement update valid |
| retire_pc | input | PC_W | PC of the retired branch |
| retire_kind | input | 3 | Kind of the retired branch, same encoding as fetch_kind |
| retire_taken | input | 1 | Resolved outcome |
| retire_target | input | PC_W | Resolved target |

## Verification
The bench builds the block with its default parameters. These are a 32-bit PC, 64 buffer entries, a 16-entry stack and the static backward rule enabled. With these values, PCs that are 256 bytes apart share an index, which makes tag replacement easy to reach. Seventeen calls are enough to wrap the stack, so the overwrite of the oldest entry is exercised in full. The counter is walked into both saturation limits through retirement-only cycles, and a same-index lookup and write are placed in one cycle.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
   typedef enum logic [2:0] {
      BK_NONE = 3'd0,
      BK_COND = 3'd1,
      BK_JUMP = 3'd2,
      BK_CALL = 3'd3,
      BK_RET  = 3'd4,
      BK_IND  = 3'd5,
      BK_FAR  = 3'd6
   } br_kind_e;

   localparam logic [1:0] CTR_WEAK_T  = 2'd2;
   localparam logic [1:0] CTR_WEAK_NT = 2'd1;
   localparam logic [1:0] CTR_MAX     = 2'd3;

   function automatic logic is_near(input logic [2:0] k);
      return (k >= 3'd1) && (k <= 3'd5);
   endfunction
endpackage

// File: rtl/bpred_btb.sv
module bpred_btb #(
   parameter int PC_W      = 32,
   parameter int ENTRIES   = 64,
   parameter int ALIGN_LSB = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] rd_pc,
   output logic            rd_hit,
   output logic [1:0]      rd_ctr,
   output logic [PC_W-1:0] rd_target,
   input  logic            wr_en,
   input  logic [PC_W-1:0] wr_pc,
   input  logic            wr_taken,
   input  logic [PC_W-1:0] wr_target
);
   import bpred_pkg::*;

   localparam int IDX_W = $clog2(ENTRIES);
   localparam int TAG_LSB = IDX_W + ALIGN_LSB;
   localparam int TAG_W = PC_W - TAG_LSB;

   initial begin
      assert (ENTRIES >= 2 && (ENTRIES & (ENTRIES - 1)) == 0)
         else $error("bpred_btb: ENTRIES must be a power of two");
      assert (TAG_W >= 1) else $error("bpred_btb: PC too narrow for index");
   end

   logic [ENTRIES-1:0] ent_valid;
   logic [TAG_W-1:0]   ent_tag [ENTRIES];
   logic [1:0]         ent_ctr [ENTRIES];
   logic [PC_W-1:0]    ent_tgt [ENTRIES];

   logic [IDX_W-1:0] rd_idx, wr_idx;
   logic [TAG_W-1:0] rd_tag, wr_tag;
   logic             wr_hit;
   logic [1:0]       wr_ctr_next;
   logic [PC_W-1:0]  wr_tgt_next;

   assign rd_idx = rd_pc[TAG_LSB-1:ALIGN_LSB];
   assign rd_tag = rd_pc[PC_W-1:TAG_LSB];
   assign wr_idx = wr_pc[TAG_LSB-1:ALIGN_LSB];
   assign wr_tag = wr_pc[PC_W-1:TAG_LSB];

   assign rd_hit    = ent_valid[rd_idx] && (ent_tag[rd_idx] == rd_tag);
   assign rd_ctr    = ent_ctr[rd_idx];
   assign rd_target = ent_tgt[rd_idx];

   assign wr_hit = ent_valid[wr_idx] && (ent_tag[wr_idx] == wr_tag);

   always_comb begin
      if (!wr_hit) begin
         wr_ctr_next = wr_taken ? CTR_WEAK_T : CTR_WEAK_NT;
         wr_tgt_next = wr_target;
      end else begin
         wr_ctr_next = ent_ctr[wr_idx];
         wr_tgt_next = ent_tgt[wr_idx];
         if (wr_taken) begin
            wr_tgt_next = wr_target;
            if (ent_ctr[wr_idx] != CTR_MAX) wr_ctr_next = ent_ctr[wr_idx] + 2'd1;
         end else if (ent_ctr[wr_idx] != 2'd0) begin
            wr_ctr_next = ent_ctr[wr_idx] - 2'd1;
         end
      end
   end

   for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
      logic we;
      assign we = wr_en && (wr_idx == IDX_W'(i));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_valid[i] <= 1'b0;
            ent_tag[i]   <= '0;
            ent_ctr[i]   <= '0;
            ent_tgt[i]   <= '0;
         end else if (we) begin
            ent_valid[i] <= 1'b1;
            ent_tag[i]   <= wr_tag;
            ent_ctr[i]   <= wr_ctr_next;
            ent_tgt[i]   <= wr_tgt_next;
         end
      end
   end

   AST_ONLY_RETIRE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ent_valid)) else $error("buffer changed without update"); // R6

   AST_ALLOC_WEAK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_hit) |=> (ent_ctr[$past(wr_idx)] == ($past(wr_taken) ? 2'd2 : 2'd1)))
      else $error("allocation counter wrong"); // R5

   AST_CTR_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_hit && wr_taken && ent_ctr[wr_idx] == 2'd3) |=> (ent_ctr[$past(wr_idx)] == 2'd3))
      else $error("counter overflowed"); // R4
endmodule

// File: rtl/bpred_ras.sv
module bpred_ras #(
   parameter int PC_W  = 32,
   parameter int DEPTH = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic [PC_W-1:0] push_addr,
   input  logic            pop,
   output logic            empty,
   output logic [PC_W-1:0] top
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("bpred_ras: DEPTH must be a power of two");
   end

   logic [PC_W-1:0]  slot [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [CNT_W-1:0] count;
   logic [PTR_W-1:0] top_ptr;

   assign top_ptr = wr_ptr - PTR_W'(1);
   assign empty   = (count == '0);
   assign top     = slot[top_ptr];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) slot[i] <= '0;
         else if (push && wr_ptr == PTR_W'(i)) slot[i] <= push_addr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         count  <= '0;
      end else if (push) begin
         wr_ptr <= wr_ptr + PTR_W'(1);
         if (count != CNT_W'(DEPTH)) count <= count + CNT_W'(1);
      end else if (pop && !empty) begin
         wr_ptr <= top_ptr;
         count  <= count - CNT_W'(1);
      end
   end

   AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (push && count != CNT_W'(DEPTH)) |=> (count == $past(count) + CNT_W'(1)))
      else $error("push did not grow stack"); // R8

   AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (push && count == CNT_W'(DEPTH)) |=> (count == CNT_W'(DEPTH)))
      else $error("overflow changed depth"); // R10

   AST_PUSHED_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (top == $past(push_addr)))
      else $error("pushed address not on top"); // R9
endmodule

// File: rtl/bpred_select.sv
module bpred_select #(
   parameter int PC_W       = 32,
   parameter bit STATIC_BWD = 1'b1
) (
   input  logic            valid,
   input  logic [2:0]      kind,
   input  logic            backward,
   input  logic [PC_W-1:0] dec_target,
   input  logic [PC_W-1:0] seq_pc,
   input  logic            btb_hit,
   input  logic [1:0]      btb_ctr,
   input  logic [PC_W-1:0] btb_target,
   input  logic            ras_empty,
   input  logic [PC_W-1:0] ras_top,
   output logic            taken,
   output logic [PC_W-1:0] next_pc,
   output logic            ras_push,
   output logic            ras_pop
);
   import bpred_pkg::*;

   logic miss_taken;

   if (STATIC_BWD) begin : g_static_bwd
      assign miss_taken = backward;
   end else begin : g_static_nt
      assign miss_taken = 1'b0;
   end

   always_comb begin
      taken    = 1'b0;
      next_pc  = seq_pc;
      ras_push = 1'b0;
      ras_pop  = 1'b0;
      case (br_kind_e'(kind))
         BK_COND: begin
            if (btb_hit) begin
               taken   = btb_ctr[1];
               next_pc = btb_ctr[1] ? btb_target : seq_pc;
            end else begin
               taken   = miss_taken;
               next_pc = miss_taken ? dec_target : seq_pc;
            end
         end
         BK_JUMP: begin
            taken   = 1'b1;
            next_pc = dec_target;
         end
         BK_CALL: begin
            taken    = 1'b1;
            next_pc  = dec_target;
            ras_push = valid;
         end
         BK_RET: begin
            if (!ras_empty) begin
               taken   = 1'b1;
               next_pc = ras_top;
               ras_pop = valid;
            end else if (btb_hit) begin
               taken   = 1'b1;
               next_pc = btb_target;
            end
         end
         BK_IND: begin
            if (btb_hit) begin
               taken   = 1'b1;
               next_pc = btb_target;
            end
         end
         default: begin
            taken   = 1'b0;
            next_pc = seq_pc;
         end
      endcase
   end
endmodule

// File: rtl/bpred_unit.sv
module bpred_unit #(
   parameter int PC_W        = 32,
   parameter int BTB_ENTRIES = 64,
   parameter int RAS_DEPTH   = 16,
   parameter int INST_BYTES  = 4,
   parameter bit STATIC_BWD  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fetch_valid,
   input  logic [PC_W-1:0] fetch_pc,
   input  logic [2:0]      fetch_kind,
   input  logic            fetch_backward,
   input  logic [PC_W-1:0] fetch_target,
   output logic            pred_taken,
   output logic [PC_W-1:0] pred_next_pc,
   input  logic            retire_valid,
   input  logic [PC_W-1:0] retire_pc,
   input  logic [2:0]      retire_kind,
   input  logic            retire_taken,
   input  logic [PC_W-1:0] retire_target
);
   import bpred_pkg::*;

   localparam int ALIGN_LSB = $clog2(INST_BYTES);

   initial begin
      assert (INST_BYTES >= 1 && (INST_BYTES & (INST_BYTES - 1)) == 0)
         else $error("bpred_unit: INST_BYTES must be a power of two");
   end

   logic [PC_W-1:0] seq_pc;
   logic            btb_hit;
   logic [1:0]      btb_ctr;
   logic [PC_W-1:0] btb_target;
   logic            ras_empty, ras_push, ras_pop;
   logic [PC_W-1:0] ras_top;
   logic            btb_we;

   assign seq_pc = fetch_pc + PC_W'(INST_BYTES);
   assign btb_we = retire_valid && is_near(retire_kind);

   bpred_btb #(.PC_W(PC_W), .ENTRIES(BTB_ENTRIES), .ALIGN_LSB(ALIGN_LSB)) u_btb (
      .clk(clk), .rst_n(rst_n),
      .rd_pc(fetch_pc), .rd_hit(btb_hit), .rd_ctr(btb_ctr), .rd_target(btb_target),
      .wr_en(btb_we), .wr_pc(retire_pc), .wr_taken(retire_taken), .wr_target(retire_target)
   );

   bpred_ras #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
      .clk(clk), .rst_n(rst_n),
      .push(ras_push), .push_addr(seq_pc), .pop(ras_pop),
      .empty(ras_empty), .top(ras_top)
   );

   bpred_select #(.PC_W(PC_W), .STATIC_BWD(STATIC_BWD)) u_sel (
      .valid(fetch_valid), .kind(fetch_kind), .backward(fetch_backward),
      .dec_target(fetch_target), .seq_pc(seq_pc),
      .btb_hit(btb_hit), .btb_ctr(btb_ctr), .btb_target(btb_target),
      .ras_empty(ras_empty), .ras_top(ras_top),
      .taken(pred_taken), .next_pc(pred_next_pc),
      .ras_push(ras_push), .ras_pop(ras_pop)
   );

   AST_FAR_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && fetch_kind == 3'd6) |-> (!pred_taken && pred_next_pc == fetch_pc + PC_W'(INST_BYTES)))
      else $error("far transfer predicted"); // R12

   AST_FAR_NO_STACK: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_kind == 3'd6) |=> $stable(ras_empty) && $stable(ras_top))
      else $error("far transfer touched stack"); // R12

   AST_CALL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && fetch_kind == 3'd3) |-> (pred_taken && pred_next_pc == fetch_target))
      else $error("call not taken to target"); // R8
endmodule

// File: tb/bpred_unit_test.sv
`timescale 1ns/1ps
module bpred_unit_test;
   localparam int PC_W = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            fetch_valid = 1'b0;
   logic [PC_W-1:0] fetch_pc = '0;
   logic [2:0]      fetch_kind = '0;
   logic            fetch_backward = 1'b0;
   logic [PC_W-1:0] fetch_target = '0;
   logic            pred_taken;
   logic [PC_W-1:0] pred_next_pc;
   logic            retire_valid = 1'b0;
   logic [PC_W-1:0] retire_pc = '0;
   logic [2:0]      retire_kind = '0;
   logic            retire_taken = 1'b0;
   logic [PC_W-1:0] retire_target = '0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      logic            taken;
      logic [PC_W-1:0] npc;
      string           req;
   } exp_t;
   exp_t expq[$];

   always #2.5 clk = ~clk;

   bpred_unit uut (
      .clk(clk), .rst_n(rst_n),
      .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .fetch_kind(fetch_kind),
      .fetch_backward(fetch_backward), .fetch_target(fetch_target),
      .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
      .retire_valid(retire_valid), .retire_pc(retire_pc), .retire_kind(retire_kind),
      .retire_taken(retire_taken), .retire_target(retire_target)
   );

   // Monitor: compares the outputs against the queued expectations, away from the edge.
   always @(negedge clk) begin
      #1;
      while (expq.size() > 0) begin
         exp_t e;
         e = expq.pop_front();
         checks++;
         if (pred_taken !== e.taken || pred_next_pc !== e.npc) begin
            errors++;
            $display("FAIL %s: taken=%0b next=%h expected taken=%0b next=%h",
                     e.req, pred_taken, pred_next_pc, e.taken, e.npc);
         end
      end
   end

   // Driver: one cycle of fetch and/or retirement stimulus.
   task automatic cyc(input bit fv, input logic [2:0] fk, input logic [PC_W-1:0] fpc,
                      input logic [PC_W-1:0] ftgt, input bit fbwd,
                      input bit rv, input logic [2:0] rk, input logic [PC_W-1:0] rpc,
                      input bit rtk, input logic [PC_W-1:0] rtgt,
                      input bit chk, input bit et, input logic [PC_W-1:0] en, input string req);
      exp_t e;
      @(negedge clk);
      fetch_valid = fv; fetch_kind = fk; fetch_pc = fpc; fetch_target = ftgt; fetch_backward = fbwd;
      retire_valid = rv; retire_kind = rk; retire_pc = rpc; retire_taken = rtk; retire_target = rtgt;
      if (chk) begin
         e.taken = et; e.npc = en; e.req = req;
         expq.push_back(e);
      end
      @(posedge clk);
   endtask

   task automatic look(input logic [2:0] k, input logic [PC_W-1:0] pc, input logic [PC_W-1:0] tgt,
                       input bit bwd, input bit et, input logic [PC_W-1:0] en, input string req);
      cyc(1, k, pc, tgt, bwd, 0, 0, 0, 0, 0, 1, et, en, req);
   endtask

   task automatic retire(input logic [2:0] k, input logic [PC_W-1:0] pc, input bit tk,
                         input logic [PC_W-1:0] tgt);
      cyc(0, 0, 0, 0, 0, 1, k, pc, tk, tgt, 0, 0, 0, "");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state: empty buffer, forward conditional is not taken
      look(3'd1, 32'h100, 32'h180, 0, 0, 32'h104, "R1");
      // R2 backward miss taken to decoded target
      look(3'd1, 32'h200, 32'h1F0, 1, 1, 32'h1F0, "R2");
      // R7 same-cycle update and lookup on index 0: old (empty) contents seen
      cyc(1, 3'd1, 32'h100, 32'h180, 0, 1, 3'd1, 32'h100, 1, 32'h180, 1, 0, 32'h104, "R7");
      // R5/R3 allocation taken -> counter 2 -> predicted taken; R6 repeated lookups do not alter
      look(3'd1, 32'h100, 32'h180, 0, 1, 32'h180, "R5");
      look(3'd1, 32'h100, 32'h180, 0, 1, 32'h180, "R6");
      // R4 decrement to 1 -> not taken
      retire(3'd1, 32'h100, 0, 32'h180);
      look(3'd1, 32'h100, 32'h180, 0, 0, 32'h104, "R4");
      // R4 saturate at 0 then one taken -> 1 -> not taken
      retire(3'd1, 32'h100, 0, 32'h180);
      retire(3'd1, 32'h100, 0, 32'h180);
      retire(3'd1, 32'h100, 1, 32'h180);
      look(3'd1, 32'h100, 32'h180, 0, 0, 32'h104, "R4");
      // R4 saturate at 3 then one not-taken -> 2 -> taken
      retire(3'd1, 32'h100, 1, 32'h180);
      retire(3'd1, 32'h100, 1, 32'h180);
      retire(3'd1, 32'h100, 1, 32'h180);
      retire(3'd1, 32'h100, 1, 32'h180);
      retire(3'd1, 32'h100, 0, 32'h180);
      look(3'd1, 32'h100, 32'h180, 0, 1, 32'h180, "R4");
      // R5 not-taken allocation -> counter 1; hit overrides static backward rule (R3)
      retire(3'd1, 32'h340, 0, 32'h380);
      look(3'd1, 32'h340, 32'h2F0, 1, 0, 32'h344, "R3");
      retire(3'd1, 32'h340, 1, 32'h380);
      look(3'd1, 32'h340, 32'h2F0, 1, 1, 32'h380, "R3");
      // R5 replacement: 0x200 shares index 0 with 0x100, different tag
      retire(3'd1, 32'h200, 1, 32'h1F0);
      look(3'd1, 32'h100, 32'h180, 0, 0, 32'h104, "R5");
      // R13 indirect miss/hit and direct jump
      look(3'd5, 32'h400, 32'h0, 0, 0, 32'h404, "R13");
      retire(3'd5, 32'h400, 1, 32'h5000);
      look(3'd5, 32'h400, 32'h0, 0, 1, 32'h5000, "R13");
      look(3'd2, 32'h600, 32'h700, 0, 1, 32'h700, "R13");
      // R12 far: not predicted and not allocated
      look(3'd6, 32'h800, 32'h9000, 0, 0, 32'h804, "R12");
      retire(3'd6, 32'h840, 1, 32'h9000);
      look(3'd1, 32'h840, 32'h880, 0, 0, 32'h844, "R12");
      // R11 empty-stack return: miss then hit
      look(3'd4, 32'hA00, 32'h0, 0, 0, 32'hA04, "R11");
      retire(3'd4, 32'hA00, 1, 32'hB00);
      look(3'd4, 32'hA00, 32'h0, 0, 1, 32'hB00, "R11");
      // R8/R9 nested calls, a far transfer between, then LIFO returns
      look(3'd3, 32'h1000, 32'h2000, 0, 1, 32'h2000, "R8");
      look(3'd3, 32'h2010, 32'h3000, 0, 1, 32'h3000, "R8");
      look(3'd6, 32'h3004, 32'h0, 0, 0, 32'h3008, "R12");
      look(3'd4, 32'h3010, 32'h0, 0, 1, 32'h2014, "R9");
      look(3'd4, 32'h2020, 32'h0, 0, 1, 32'h1004, "R9");
      look(3'd4, 32'hA00, 32'h0, 0, 1, 32'hB00, "R11");
      // R10 overflow: 17 calls, 16 returns newest first, then empty
      for (int i = 0; i < 17; i++)
         look(3'd3, 32'h4000 + 32'(i * 16), 32'h8000, 0, 1, 32'h8000, "R10");
      for (int i = 16; i >= 1; i--)
         look(3'd4, 32'h8000, 32'h0, 0, 1, 32'h4000 + 32'(i * 16) + 32'h4, "R10");
      look(3'd4, 32'hA00, 32'h0, 0, 1, 32'hB00, "R10");

      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
      @(negedge clk);
      #2;
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule